// File: doc/BRIEF.md
# USB Endpoint Control Bank with Token Admission

This block holds the control state for sixteen USB device endpoints and decides, for every token the protocol engine decodes, how that token is handled. Each endpoint owns a small control register with five live bits. These are a handshake enable, a control-transfer disable, an OUT enable, an IN enable and a sticky stall flag. Firmware reads the registers through a combinational read port and writes them through a write port that updates on the next clock edge.

The protocol engine presents a token with its type and endpoint number. One cycle later the block reports whether the token is admitted, whether a handshake packet should follow, and whether that handshake must be STALL. The engine can also request a stall on any endpoint, which sets that endpoint's stall flag. An admitted SETUP token clears the flag of its endpoint. A stall request outranks both that clear and any firmware write made in the same cycle.

Top module: `usb_ep_ctrl_bank`

## Requirements
- R1: After a synchronous reset every implemented bit of every endpoint register is 0, and the three token outputs are 0.
- R2: A write to endpoint register `reg_addr` stores bits 4:0 of `reg_wdata` at the next rising edge. The layout is bit 4 handshake enable, bit 3 control disable, bit 2 OUT enable, bit 1 IN enable, bit 0 stall. Bits 7:5 ignore writes and always read 0. `reg_rdata` shows the addressed register combinationally.
- R3: Token type encoding is OUT=0, IN=1, SETUP=2 and reserved=3. An OUT token is admitted only when bit 2 of its endpoint is 1, and an IN token only when bit 1 is 1. A reserved token is never admitted.
- R4: A SETUP token is admitted only when bits 2 and 1 of its endpoint are both 1 and bit 3 is 0.
- R5: When bits 2 and 1 of an endpoint are both 0, no token to that endpoint is admitted, and no handshake or stall is reported, whatever bits 4, 3 and 0 hold.
- R6: `tok_handshake` is 1 exactly when the token is admitted and bit 4 of its endpoint is 1.
- R7: `tok_stall` is 1 exactly when an admitted IN or OUT token meets an endpoint whose bit 0 is 1. An admitted SETUP token never reports a stall.
- R8: `stall_req` sets bit 0 of endpoint `stall_ep` at the next edge. This overrides a firmware write and a SETUP clear to that endpoint in the same cycle.
- R9: An admitted SETUP token clears bit 0 of its endpoint at the next edge. This clear overrides a firmware write to that endpoint in the same cycle.
- R10: The token outputs are registered. They appear one cycle after `tok_valid` and are computed from the register contents present in the token cycle. In a cycle after `tok_valid` was 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Firmware register write strobe |
| reg_addr | input | 4 | Endpoint register selected for read and write |
| reg_wdata | input | 8 | Firmware write data |
| reg_rdata | output | 8 | Addressed register contents, combinational |
| tok_valid | input | 1 | A token is presented this cycle |
| tok_type | input | 2 | Token type: OUT=0, IN=1, SETUP=2, reserved=3 |
| tok_ep | input | 4 | Endpoint number of the token |
| stall_req | input | 1 | Engine request to set a stall flag |
| stall_ep | input | 4 | Endpoint targeted by the stall request |
| tok_accept | output | 1 | Token admitted (one cycle after the token) |
| tok_handshake | output | 1 | A handshake packet should be sent |
| tok_stall | output | 1 | The handshake must be STALL |

## Verification
A corrupted stall flag or enable bit shows up at the ports in one of two ways. It is visible on `reg_rdata` in the same cycle it is addressed, and in the token outputs one cycle after the next token that reaches the affected endpoint. The most delicate state is the stall flag, because three sources contend for it in one cycle: the engine set, the SETUP clear and the firmware write. Precedence errors among them only show when those sources collide on the same endpoint, so the stimulus forces such collisions as well as random mixes. A wrong admission path shows at the ports one cycle after the offending token, and the bench compares every output on every cycle against the reference model.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2,
    TOK_RSVD  = 2'd3
  } tok_kind_e;

  // Packed so that the field order matches the register bit positions 4..0.
  typedef struct packed {
    logic hs_en;
    logic ctl_dis;
    logic out_en;
    logic in_en;
    logic stall;
  } ep_ctrl_t;

  localparam int CTRL_W = $bits(ep_ctrl_t);

endpackage

// File: rtl/usb_ep_reg.sv
module usb_ep_reg
  import usb_ep_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  ep_ctrl_t wr_data,
  input  logic     set_stall,
  input  logic     clr_stall,
  output ep_ctrl_t ctrl_q
);

  ep_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) ctrl_d = wr_data;
    if (clr_stall) ctrl_d.stall = 1'b0;
    if (set_stall) ctrl_d.stall = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  // R8: engine stall request always lands
  p_stall_set_r8: assert property (@(posedge clk) disable iff (rst)
    set_stall |=> ctrl_q.stall);

  // R9: SETUP clear lands unless a set collides
  p_setup_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_stall && !set_stall) |=> !ctrl_q.stall);

  // R2: an uncontested write stores all live bits
  p_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !set_stall && !clr_stall) |=> (ctrl_q == $past(wr_data)));

  // R2: with no source active the register holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !set_stall && !clr_stall) |=> $stable(ctrl_q));

endmodule

// File: rtl/usb_ep_admit.sv
module usb_ep_admit
  import usb_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tok_valid_i,
  input  logic [1:0] tok_type_i,
  input  ep_ctrl_t   ctrl_i,
  output logic       setup_ok_o,
  output logic       tok_acc_o,
  output logic       tok_hs_o,
  output logic       tok_stall_o
);

  tok_kind_e kind;
  logic      ep_live;
  logic      dir_ok;
  logic      acc_d;
  logic      hs_d;
  logic      stall_d;

  always_comb begin
    kind    = tok_kind_e'(tok_type_i);
    ep_live = ctrl_i.out_en | ctrl_i.in_en;
    unique case (kind)
      TOK_OUT:   dir_ok = ctrl_i.out_en;
      TOK_IN:    dir_ok = ctrl_i.in_en;
      TOK_SETUP: dir_ok = ctrl_i.out_en & ctrl_i.in_en & ~ctrl_i.ctl_dis;
      default:   dir_ok = 1'b0;
    endcase
    acc_d      = tok_valid_i & ep_live & dir_ok;
    hs_d       = acc_d & ctrl_i.hs_en;
    stall_d    = acc_d & ctrl_i.stall & (kind != TOK_SETUP);
    setup_ok_o = acc_d & (kind == TOK_SETUP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tok_acc_o   <= 1'b0;
      tok_hs_o    <= 1'b0;
      tok_stall_o <= 1'b0;
    end else begin
      tok_acc_o   <= acc_d;
      tok_hs_o    <= hs_d;
      tok_stall_o <= stall_d;
    end
  end

  // R6: no handshake without admission
  p_hs_needs_acc_r6: assert property (@(posedge clk) disable iff (rst)
    tok_hs_o |-> tok_acc_o);

  // R7: no stall without admission
  p_stall_needs_acc_r7: assert property (@(posedge clk) disable iff (rst)
    tok_stall_o |-> tok_acc_o);

  // R4: SETUP refused when a direction is off
  p_setup_dirs_r4: assert property (@(posedge clk) disable iff (rst)
    (tok_valid_i && tok_type_i == 2'd2 && !(ctrl_i.out_en && ctrl_i.in_en))
      |=> !tok_acc_o);

  // R10: idle cycle gives quiet outputs
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !tok_valid_i |=> (!tok_acc_o && !tok_hs_o && !tok_stall_o));

endmodule

// File: rtl/usb_ep_ctrl_bank.sv
module usb_ep_ctrl_bank
  import usb_ep_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int REG_W  = 8,
  parameter int EP_AW  = $clog2(NUM_EP)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [EP_AW-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             tok_valid,
  input  logic [1:0]       tok_type,
  input  logic [EP_AW-1:0] tok_ep,
  input  logic             stall_req,
  input  logic [EP_AW-1:0] stall_ep,
  output logic             tok_accept,
  output logic             tok_handshake,
  output logic             tok_stall
);

  localparam int PAD_W = REG_W - CTRL_W;

  ep_ctrl_t bank  [NUM_EP];
  ep_ctrl_t wdata_f;
  ep_ctrl_t tok_ctrl;
  logic     setup_ok;

  assign wdata_f = ep_ctrl_t'(reg_wdata[CTRL_W-1:0]);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    logic wr_hit, set_hit, clr_hit;
    assign wr_hit  = reg_we    && (reg_addr == EP_AW'(i));
    assign set_hit = stall_req && (stall_ep == EP_AW'(i));
    assign clr_hit = setup_ok  && (tok_ep   == EP_AW'(i));

    usb_ep_reg u_reg (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_hit),
      .wr_data   (wdata_f),
      .set_stall (set_hit),
      .clr_stall (clr_hit),
      .ctrl_q    (bank[i])
    );
  end

  assign reg_rdata = {{PAD_W{1'b0}}, bank[reg_addr]};
  assign tok_ctrl  = bank[tok_ep];

  usb_ep_admit u_admit (
    .clk         (clk),
    .rst         (rst),
    .tok_valid_i (tok_valid),
    .tok_type_i  (tok_type),
    .ctrl_i      (tok_ctrl),
    .setup_ok_o  (setup_ok),
    .tok_acc_o   (tok_accept),
    .tok_hs_o    (tok_handshake),
    .tok_stall_o (tok_stall)
  );

  // R2: unimplemented bits read as zero
  p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:CTRL_W] == '0);

  // R5: a dead endpoint admits nothing
  p_dead_ep_r5: assert property (@(posedge clk) disable iff (rst)
    (tok_valid && !tok_ctrl.out_en && !tok_ctrl.in_en) |=> !tok_accept);

endmodule

// File: tb/usb_ep_ctrl_bank_tb.sv
module usb_ep_ctrl_bank_tb;

  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tok_valid;
  logic [1:0] tok_type;
  logic [3:0] tok_ep;
  logic       stall_req;
  logic [3:0] stall_ep;
  logic       tok_accept, tok_handshake, tok_stall;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [4:0] mdl [16];

  always #(CLK_NS/2) clk = ~clk;

  usb_ep_ctrl_bank u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tok_valid(tok_valid),
    .tok_type(tok_type), .tok_ep(tok_ep), .stall_req(stall_req),
    .stall_ep(stall_ep), .tok_accept(tok_accept),
    .tok_handshake(tok_handshake), .tok_stall(tok_stall)
  );

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string pick_tag(input logic tv, input logic [1:0] tt,
                                     input logic [4:0] c);
    if (!tv) return "R10";
    if (!c[2] && !c[1]) return "R5";
    if (tt == 2'd2) return "R4";
    if (c[0]) return "R7";
    if (c[4]) return "R6";
    return "R3";
  endfunction

  // One cycle: drive after the falling edge, check the read port, model the
  // edge, then compare the registered outputs at the next falling edge.
  task automatic step(input logic we, input logic [3:0] wa, input logic [7:0] wd,
                      input logic tv, input logic [1:0] tt, input logic [3:0] te,
                      input logic sr, input logic [3:0] se, input string tag);
    logic [4:0] c;
    logic live, ok, acc, hs, stl;
    string t;
    reg_we = we; reg_addr = wa; reg_wdata = wd;
    tok_valid = tv; tok_type = tt; tok_ep = te;
    stall_req = sr; stall_ep = se;
    #1;
    check("R2", "rdata", int'(reg_rdata), int'({3'b000, mdl[wa]}));
    c    = mdl[te];
    live = c[2] | c[1];
    case (tt)
      2'd0:    ok = c[2];
      2'd1:    ok = c[1];
      2'd2:    ok = c[2] & c[1] & ~c[3];
      default: ok = 1'b0;
    endcase
    acc = tv & live & ok;
    hs  = acc & c[4];
    stl = acc & c[0] & (tt != 2'd2);
    for (int i = 0; i < 16; i++) begin
      if (we && wa == 4'(i)) mdl[i] = wd[4:0];
      if (acc && tt == 2'd2 && te == 4'(i)) mdl[i][0] = 1'b0;
      if (sr && se == 4'(i)) mdl[i][0] = 1'b1;
    end
    t = (tag == "") ? pick_tag(tv, tt, c) : tag;
    @(negedge clk);
    check(t, "accept", int'(tok_accept), int'(acc));
    check(t, "handshake", int'(tok_handshake), int'(hs));
    check(t, "stall", int'(tok_stall), int'(stl));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0, 2'd0, 4'd0, 1'b0, 4'd0, "R2");
  endtask

  task automatic tok(input logic [1:0] tt, input logic [3:0] e, input string tag);
    step(1'b0, e, 8'h00, 1'b1, tt, e, 1'b0, 4'd0, tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    rst = 1'b1; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    tok_valid = 0; tok_type = 0; tok_ep = 0; stall_req = 0; stall_ep = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state on every register and on the outputs
    for (int i = 0; i < 16; i++) begin
      reg_addr = 4'(i); #1;
      check("R1", "reset rdata", int'(reg_rdata), 0);
    end
    check("R1", "reset accept", int'(tok_accept), 0);
    check("R1", "reset handshake", int'(tok_handshake), 0);
    check("R1", "reset stall", int'(tok_stall), 0);
    @(negedge clk);

    // R2: upper bits dropped
    wr(4'd3, 8'hFF);
    step(1'b0, 4'd3, 8'h00, 1'b0, 2'd0, 4'd0, 1'b0, 4'd0, "R2");
    // R5: all bits but the enables set, nothing admitted
    wr(4'd5, 8'h19);
    tok(2'd0, 4'd5, "R5"); tok(2'd1, 4'd5, "R5"); tok(2'd2, 4'd5, "R5");
    // R3: direction gating, reserved code
    wr(4'd1, 8'h14);
    tok(2'd0, 4'd1, "R3"); tok(2'd1, 4'd1, "R3"); tok(2'd3, 4'd1, "R3");
    // R4: SETUP gating by both enables and control disable
    tok(2'd2, 4'd1, "R4");
    wr(4'd0, 8'h16); tok(2'd2, 4'd0, "R4");
    wr(4'd0, 8'h1E); tok(2'd2, 4'd0, "R4");
    // R6: isochronous style, no handshake
    wr(4'd2, 8'h06); tok(2'd1, 4'd2, "R6");
    // R8: stall request beats a same-cycle write clearing it
    step(1'b1, 4'd0, 8'h16, 1'b0, 2'd0, 4'd0, 1'b1, 4'd0, "R8");
    step(1'b0, 4'd0, 8'h00, 1'b0, 2'd0, 4'd0, 1'b0, 4'd0, "R8");
    // R7: stalled IN and OUT
    tok(2'd1, 4'd0, "R7"); tok(2'd0, 4'd0, "R7");
    // R9: SETUP reports no stall and clears the flag, beating a write
    step(1'b1, 4'd0, 8'h17, 1'b1, 2'd2, 4'd0, 1'b0, 4'd0, "R9");
    step(1'b0, 4'd0, 8'h00, 1'b1, 2'd1, 4'd0, 1'b0, 4'd0, "R9");
    // R8: stall request also beats a SETUP clear
    step(1'b0, 4'd0, 8'h00, 1'b1, 2'd2, 4'd0, 1'b1, 4'd0, "R8");
    step(1'b0, 4'd0, 8'h00, 1'b1, 2'd0, 4'd0, 1'b0, 4'd0, "R8");
    // R10: output follows register state of the token cycle, not after
    step(1'b1, 4'd7, 8'h14, 1'b1, 2'd0, 4'd7, 1'b0, 4'd0, "R10");
    tok(2'd0, 4'd7, "R10");
    step(1'b0, 4'd7, 8'h00, 1'b0, 2'd0, 4'd7, 1'b0, 4'd0, "R10");

    // Random mix with forced collisions on a few endpoints
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] a, e, s;
      a = 4'($urandom_range(0, 3));
      e = 4'($urandom_range(0, 3));
      s = ($urandom_range(0, 3) == 0) ? e : 4'($urandom_range(0, 15));
      step(($urandom_range(0, 3) == 0), a, 8'($urandom),
           ($urandom_range(0, 3) != 0), 2'($urandom), e,
           ($urandom_range(0, 7) == 0), s, "");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule